// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block chooses which event a processor core takes when a take strobe arrives, and computes the architectural state the core enters with. Its inputs are:

- a pending exception code, or none;
- a hard-interrupt request, with the vector supplied by an external priority resolver;
- the sleep flag;
- the current status word, program counter, vector base, stack pointer and delay-slot flags.

On an entry it registers the following, all in one clock edge:

- copies of the pre-entry status, program counter and stack pointer;
- the exception or interrupt event code;
- the updated status word and the handler address.

The core pulses `take_i` for one cycle when it is ready to accept an event. One cycle later `entered_o` reports whether anything was taken. When nothing was taken, every registered output holds its previous value.

The block drives the interrupt mask `irq_mask_o` straight from the status word, so the resolver can answer in the same cycle. A blocked-state status bit turns masked exceptions into a reset. Handler addresses fall into four classes: reset, translation miss, general and interrupt. Trap and delay-slot events adjust the saved program counter. All ports are plain control and data pins. The strobe carries no back-pressure: the core raises it only when it can consume the result.

Top module: `exc_entry_seq`

## Requirements
- R1: When `take_i` is high and `exc_pending_i` is high, the exception is taken even if an interrupt is requested. `expevt_o` receives the exception code and `intevt_o` keeps its previous value.
- R2: When status bit 28 (blocked) is set, a pending exception with any code except 0x1E0 is recorded and dispatched as code 0x000. Code 0x1E0 passes through unchanged.
- R3: With status bit 28 set and no exception pending, an interrupt request is taken only when `sleep_i` is high. Otherwise `entered_o` stays low and every output holds its value.
- R4: `irq_mask_o` always equals status bits [7:4]. An interrupt request whose `irq_vec_valid_i` is low is not taken.
- R5: On entry, the block registers these values in the edge that follows the strobe: `ssr_o` = input status, `sgr_o` = input stack pointer and `entered_o` = 1. `sr_o` equals the input status with bits 28 (blocked), 29 (bank) and 30 (privileged) set and the remaining bits kept.
- R6: If delay-slot flag bit 0 or bit 1 is set on entry, `spc_o` is the input PC minus 2 and all three flags in `dslot_o` are cleared. Otherwise `spc_o` is the input PC and `dslot_o` keeps the input flags.
- R7: Exception codes 0x000, 0x020 and 0x800 set status bits [7:4] to 0xF and set the new PC to 0xA000_0000.
- R8: Exception codes 0x040 and 0x060 give new PC = vector base + 0x400. Any other non-reset exception gives vector base + 0x100.
- R9: Exception code 0x160 adds 2 to the saved PC, after any delay-slot adjustment.
- R10: A taken interrupt loads `intevt_o` with the vector, leaves `expevt_o` unchanged and gives new PC = vector base + 0x600.
- R11: When `take_i` is low, or no event qualifies, `entered_o` is 0 in the next cycle and all other registered outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle strobe: evaluate and enter now |
| exc_pending_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hard-interrupt request |
| irq_vec_valid_i | input | 1 | Resolver returned a vector above the mask |
| irq_vec_i | input | 12 | Interrupt vector from resolver |
| sleep_i | input | 1 | Core is in sleep |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| vbr_i | input | 32 | Vector base |
| sp_i | input | 32 | Current stack pointer |
| dslot_i | input | 3 | Delay-slot flags: [0] slot, [1] conditional slot, [2] condition true |
| irq_mask_o | output | 4 | Interrupt mask for the resolver |
| entered_o | output | 1 | Event entered on the last strobe |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack pointer |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |
| sr_o | output | 32 | Status word on entry |
| pc_o | output | 32 | Handler address |
| dslot_o | output | 3 | Delay-slot flags after entry |

## Verification
Exception priority and interrupt acceptance can both apply on the same strobe: an exception code and a valid interrupt vector arrive together. The bench drives this collision directly, both with the blocked bit clear and set. It judges the result by checking that `expevt_o` and the handler address follow the exception while `intevt_o` is untouched.

A delay-slot adjustment and the trap adjustment also fall in the same cycle when a trap code arrives with delay-slot flags set. The expected saved PC is then the unmodified input PC. Random strobes mix all these conditions and are compared against a bench model built from the requirements.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2
  } ev_kind_e;

  localparam int CODE_PWR_RST = 'h000;
  localparam int CODE_MAN_RST = 'h020;
  localparam int CODE_TLB_RD  = 'h040;
  localparam int CODE_TLB_WR  = 'h060;
  localparam int CODE_TRAP    = 'h160;
  localparam int CODE_BL_PASS = 'h1E0;
  localparam int CODE_HW_RST  = 'h800;

  localparam int SR_BL_BIT    = 28;
  localparam int SR_RB_BIT    = 29;
  localparam int SR_MD_BIT    = 30;
  localparam int SR_IMASK_LO  = 4;
  localparam int IMASK_W      = 4;

  localparam int OFS_TLB      = 'h400;
  localparam int OFS_GEN      = 'h100;
  localparam int OFS_IRQ      = 'h600;
  localparam longint RESET_PC = 64'hA000_0000;

  localparam int DS_W         = 3;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
#(
  parameter int EVT_W = 12
) (
  input  logic             take_i,
  input  logic             exc_pending_i,
  input  logic [EVT_W-1:0] exc_code_i,
  input  logic             irq_req_i,
  input  logic             irq_vec_valid_i,
  input  logic [EVT_W-1:0] irq_vec_i,
  input  logic             sleep_i,
  input  logic             blocked_i,
  output ev_kind_e         kind_o,
  output logic [EVT_W-1:0] code_o
);
  logic irq_allowed;

  // a blocked core only wakes on an interrupt when sleeping
  assign irq_allowed = irq_req_i && irq_vec_valid_i && (!blocked_i || sleep_i);

  always_comb begin
    kind_o = EV_NONE;
    code_o = '0;
    if (take_i) begin
      if (exc_pending_i) begin
        kind_o = EV_EXC;
        if (blocked_i && (exc_code_i != EVT_W'(CODE_BL_PASS)))
          code_o = EVT_W'(CODE_PWR_RST);
        else
          code_o = exc_code_i;
      end else if (irq_allowed) begin
        kind_o = EV_IRQ;
        code_o = irq_vec_i;
      end
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EVT_W = 12
) (
  input  ev_kind_e         kind_i,
  input  logic [EVT_W-1:0] code_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  vbr_i,
  input  logic             in_slot_i,
  output logic [XLEN-1:0]  new_pc_o,
  output logic [XLEN-1:0]  spc_o,
  output logic             force_imask_o
);
  logic is_reset, is_tlb, is_trap;
  logic [XLEN-1:0] spc_base;

  assign is_reset = (code_i == EVT_W'(CODE_PWR_RST)) ||
                    (code_i == EVT_W'(CODE_MAN_RST)) ||
                    (code_i == EVT_W'(CODE_HW_RST));
  assign is_tlb   = (code_i == EVT_W'(CODE_TLB_RD)) ||
                    (code_i == EVT_W'(CODE_TLB_WR));
  assign is_trap  = (code_i == EVT_W'(CODE_TRAP));

  // restart at the branch when the event hit its delay slot
  assign spc_base = in_slot_i ? (pc_i - XLEN'(2)) : pc_i;

  always_comb begin
    new_pc_o      = vbr_i + XLEN'(OFS_GEN);
    spc_o         = spc_base;
    force_imask_o = 1'b0;
    unique case (kind_i)
      EV_EXC: begin
        if (is_reset) begin
          new_pc_o      = XLEN'(RESET_PC);
          force_imask_o = 1'b1;
        end else if (is_tlb) begin
          new_pc_o = vbr_i + XLEN'(OFS_TLB);
        end else begin
          if (is_trap) spc_o = spc_base + XLEN'(2);
          new_pc_o = vbr_i + XLEN'(OFS_GEN);
        end
      end
      EV_IRQ:  new_pc_o = vbr_i + XLEN'(OFS_IRQ);
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EVT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ev_kind_e         kind_i,
  input  logic [EVT_W-1:0] code_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [XLEN-1:0]  spc_i,
  input  logic [XLEN-1:0]  new_pc_i,
  input  logic             force_imask_i,
  input  logic             in_slot_i,
  input  logic [DS_W-1:0]  dslot_i,
  output logic             entered_o,
  output logic [XLEN-1:0]  ssr_o,
  output logic [XLEN-1:0]  spc_o,
  output logic [XLEN-1:0]  sgr_o,
  output logic [EVT_W-1:0] expevt_o,
  output logic [EVT_W-1:0] intevt_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [DS_W-1:0]  dslot_o
);
  logic [XLEN-1:0] sr_next;

  always_comb begin
    sr_next = sr_i;
    sr_next[SR_BL_BIT] = 1'b1;
    sr_next[SR_RB_BIT] = 1'b1;
    sr_next[SR_MD_BIT] = 1'b1;
    if (force_imask_i) sr_next[SR_IMASK_LO +: IMASK_W] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entered_o <= 1'b0;
      ssr_o     <= '0;
      spc_o     <= '0;
      sgr_o     <= '0;
      expevt_o  <= '0;
      intevt_o  <= '0;
      sr_o      <= '0;
      pc_o      <= '0;
      dslot_o   <= '0;
    end else begin
      entered_o <= (kind_i != EV_NONE);
      if (kind_i != EV_NONE) begin
        ssr_o   <= sr_i;
        spc_o   <= spc_i;
        sgr_o   <= sp_i;
        sr_o    <= sr_next;
        pc_o    <= new_pc_i;
        dslot_o <= in_slot_i ? '0 : dslot_i;
        if (kind_i == EV_EXC) expevt_o <= code_i;
        else                  intevt_o <= code_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int EVT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             exc_pending_i,
  input  logic [EVT_W-1:0] exc_code_i,
  input  logic             irq_req_i,
  input  logic             irq_vec_valid_i,
  input  logic [EVT_W-1:0] irq_vec_i,
  input  logic             sleep_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  vbr_i,
  input  logic [XLEN-1:0]  sp_i,
  input  logic [2:0]       dslot_i,
  output logic [3:0]       irq_mask_o,
  output logic             entered_o,
  output logic [XLEN-1:0]  ssr_o,
  output logic [XLEN-1:0]  spc_o,
  output logic [XLEN-1:0]  sgr_o,
  output logic [EVT_W-1:0] expevt_o,
  output logic [EVT_W-1:0] intevt_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [2:0]       dslot_o
);
  ev_kind_e         kind;
  logic [EVT_W-1:0] code;
  logic [XLEN-1:0]  new_pc, spc_calc;
  logic             force_imask, in_slot;

  assign irq_mask_o = sr_i[SR_IMASK_LO +: IMASK_W];
  assign in_slot    = dslot_i[0] | dslot_i[1];

  exc_arbiter #(.EVT_W(EVT_W)) u_arb (
    .take_i          (take_i),
    .exc_pending_i   (exc_pending_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .irq_vec_i       (irq_vec_i),
    .sleep_i         (sleep_i),
    .blocked_i       (sr_i[SR_BL_BIT]),
    .kind_o          (kind),
    .code_o          (code)
  );

  exc_target #(.XLEN(XLEN), .EVT_W(EVT_W)) u_tgt (
    .kind_i        (kind),
    .code_i        (code),
    .pc_i          (pc_i),
    .vbr_i         (vbr_i),
    .in_slot_i     (in_slot),
    .new_pc_o      (new_pc),
    .spc_o         (spc_calc),
    .force_imask_o (force_imask)
  );

  exc_state_regs #(.XLEN(XLEN), .EVT_W(EVT_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .kind_i        (kind),
    .code_i        (code),
    .sr_i          (sr_i),
    .sp_i          (sp_i),
    .spc_i         (spc_calc),
    .new_pc_i      (new_pc),
    .force_imask_i (force_imask),
    .in_slot_i     (in_slot),
    .dslot_i       (dslot_i),
    .entered_o     (entered_o),
    .ssr_o         (ssr_o),
    .spc_o         (spc_o),
    .sgr_o         (sgr_o),
    .expevt_o      (expevt_o),
    .intevt_o      (intevt_o),
    .sr_o          (sr_o),
    .pc_o          (pc_o),
    .dslot_o       (dslot_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN  = 32,
  parameter int EVT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_i,
  input logic             exc_pending_i,
  input logic [EVT_W-1:0] exc_code_i,
  input logic             irq_req_i,
  input logic             irq_vec_valid_i,
  input logic [EVT_W-1:0] irq_vec_i,
  input logic             sleep_i,
  input logic [XLEN-1:0]  sr_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  vbr_i,
  input logic [XLEN-1:0]  sp_i,
  input logic [2:0]       dslot_i,
  input logic [3:0]       irq_mask_o,
  input logic             entered_o,
  input logic [XLEN-1:0]  ssr_o,
  input logic [XLEN-1:0]  spc_o,
  input logic [XLEN-1:0]  sgr_o,
  input logic [EVT_W-1:0] expevt_o,
  input logic [EVT_W-1:0] intevt_o,
  input logic [XLEN-1:0]  sr_o,
  input logic [XLEN-1:0]  pc_o,
  input logic [2:0]       dslot_o
);
  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_pending_i) |=> (entered_o && $stable(intevt_o))); // R1

  AST_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_pending_i && sr_i[28] && !sleep_i) |=> !entered_o); // R3

  AST_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_pending_i && !irq_vec_valid_i) |=> !entered_o); // R4

  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    entered_o |-> (sr_o[28] && sr_o[29] && sr_o[30])); // R5

  AST_SAVED_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!entered_o || (ssr_o == $past(sr_i) && sgr_o == $past(sp_i)))); // R5

  AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    entered_o |-> (!dslot_o[0] && !dslot_o[1])); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> (!entered_o && $stable(pc_o) && $stable(sr_o) && $stable(spc_o))); // R11
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .EVT_W(EVT_W)) u_chk (.*);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0, exc_pending_i = 1'b0, irq_req_i = 1'b0;
  logic        irq_vec_valid_i = 1'b0, sleep_i = 1'b0;
  logic [11:0] exc_code_i = '0, irq_vec_i = '0;
  logic [31:0] sr_i = '0, pc_i = '0, vbr_i = '0, sp_i = '0;
  logic [2:0]  dslot_i = '0;
  logic [3:0]  irq_mask_o;
  logic        entered_o;
  logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;
  logic [2:0]  dslot_o;

  int n_chk = 0, n_fail = 0;

  // expected state, built from the requirements
  logic        e_ent = 0;
  logic [31:0] e_ssr = 0, e_spc = 0, e_sgr = 0, e_sr = 0, e_pc = 0;
  logic [11:0] e_exp = 0, e_int = 0;
  logic [2:0]  e_ds = 0;

  always #4 clk = ~clk;

  exc_entry_seq u0 (.*);

  task automatic model(input logic tk);
    logic go, isx;
    logic [11:0] c;
    go = 0; isx = 0; c = 0;
    if (tk) begin
      if (exc_pending_i) begin
        go = 1; isx = 1;
        c = (sr_i[28] && exc_code_i != 12'h1E0) ? 12'h000 : exc_code_i;
      end else if (irq_req_i && irq_vec_valid_i && (!sr_i[28] || sleep_i)) begin
        go = 1; c = irq_vec_i;
      end
    end
    e_ent = go;
    if (go) begin
      e_ssr = sr_i; e_sgr = sp_i;
      e_spc = (dslot_i[0] | dslot_i[1]) ? pc_i - 32'd2 : pc_i;
      e_ds  = (dslot_i[0] | dslot_i[1]) ? 3'b000 : dslot_i;
      e_sr  = sr_i | 32'h7000_0000;
      if (isx) begin
        e_exp = c;
        if (c == 12'h000 || c == 12'h020 || c == 12'h800) begin
          e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) begin
          e_pc = vbr_i + 32'h400;
        end else begin
          if (c == 12'h160) e_spc = e_spc + 32'd2;
          e_pc = vbr_i + 32'h100;
        end
      end else begin
        e_int = c; e_pc = vbr_i + 32'h600;
      end
    end
  endtask

  task automatic compare(input string req);
    logic [187:0] act, exp;
    act = {entered_o, ssr_o, spc_o, sgr_o, expevt_o, intevt_o, sr_o, pc_o, dslot_o};
    exp = {e_ent, e_ssr, e_spc, e_sgr, e_exp, e_int, e_sr, e_pc, e_ds};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input string req);
    @(negedge clk);
    take_i = tk;
    model(tk);
    @(negedge clk);
    take_i = 1'b0;
    compare(req);
  endtask

  task automatic set_in(input logic ep, input logic [11:0] ec, input logic ir,
                        input logic vv, input logic [11:0] iv, input logic sl,
                        input logic [31:0] sr, input logic [31:0] pc,
                        input logic [2:0] ds);
    exc_pending_i = ep; exc_code_i = ec; irq_req_i = ir; irq_vec_valid_i = vv;
    irq_vec_i = iv; sleep_i = sl; sr_i = sr; pc_i = pc; dslot_i = ds;
    vbr_i = 32'h8C00_0000; sp_i = 32'h0C00_1F00 + {20'd0, ec};
  endtask

  function automatic logic [11:0] pick_code(input int r);
    case (r % 9)
      0: return 12'h000; 1: return 12'h020; 2: return 12'h040;
      3: return 12'h060; 4: return 12'h160; 5: return 12'h1E0;
      6: return 12'h800; 7: return 12'h0E0; default: return 12'h180;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // reset state, R11 baseline
    compare("R11 reset");
    rst_n = 1'b1;
    sr_i = 32'h0000_00A0;
    @(negedge clk);
    n_chk++;
    if (irq_mask_o !== 4'hA) begin
      n_fail++; $display("FAIL R4 mask actual=%h expected=a", irq_mask_o);
    end

    // R1: exception and interrupt in the same strobe
    set_in(1, 12'h180, 1, 1, 12'h3C0, 0, 32'h0000_0010, 32'h0C00_1000, 3'b000);
    step(1, "R1 exc beats irq");
    set_in(1, 12'h040, 1, 1, 12'h3E0, 1, 32'h1000_0010, 32'h0C00_1000, 3'b000);
    step(1, "R1 exc beats irq while blocked");
    // R2: blocked converts to reset, except 0x1E0
    set_in(1, 12'h0E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0C00_2000, 3'b000);
    step(1, "R2 blocked -> reset");
    set_in(1, 12'h1E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0C00_2004, 3'b000);
    step(1, "R2 blocked pass code");
    // R3: blocked irq
    set_in(0, 0, 1, 1, 12'h400, 0, 32'h1000_0020, 32'h0C00_3000, 3'b000);
    step(1, "R3 blocked irq ignored");
    set_in(0, 0, 1, 1, 12'h420, 1, 32'h1000_0020, 32'h0C00_3002, 3'b000);
    step(1, "R3 blocked irq while sleeping");
    // R4: no vector
    set_in(0, 0, 1, 0, 12'h500, 0, 32'h0000_0050, 32'h0C00_4000, 3'b000);
    step(1, "R4 no vector");
    // R5/R6: delay-slot general exception
    set_in(1, 12'h180, 0, 0, 0, 0, 32'h0000_0301, 32'h0C00_5006, 3'b101);
    step(1, "R5 R6 slot general");
    set_in(1, 12'h0A0, 0, 0, 0, 0, 32'h0000_0300, 32'h0C00_5006, 3'b100);
    step(1, "R6 true-flag only kept");
    // R7: reset class
    set_in(1, 12'h020, 0, 0, 0, 0, 32'h0000_0030, 32'h0C00_6000, 3'b000);
    step(1, "R7 manual reset");
    set_in(1, 12'h800, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_6002, 3'b000);
    step(1, "R7 reset 0x800");
    // R8: tlb vs general
    set_in(1, 12'h060, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_7000, 3'b000);
    step(1, "R8 tlb miss");
    set_in(1, 12'h0E0, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_7004, 3'b000);
    step(1, "R8 general");
    // R9: trap, plain and in delay slot
    set_in(1, 12'h160, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_8000, 3'b000);
    step(1, "R9 trap");
    set_in(1, 12'h160, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_8010, 3'b010);
    step(1, "R9 trap in slot");
    // R10: interrupt
    set_in(0, 0, 1, 1, 12'h5A0, 0, 32'h4000_00F0, 32'h0C00_9000, 3'b000);
    step(1, "R10 interrupt");
    // R11: no strobe / no event
    set_in(1, 12'h040, 1, 1, 12'h600, 0, 32'h0000_0000, 32'h0C00_A000, 3'b011);
    step(0, "R11 no strobe");
    set_in(0, 0, 0, 1, 12'h600, 0, 32'h0000_0000, 32'h0C00_A000, 3'b000);
    step(1, "R11 strobe no event");

    for (int i = 0; i < 400; i++) begin
      set_in($urandom % 2 == 0, pick_code($urandom), $urandom % 2 == 0,
             $urandom % 4 != 0, 12'($urandom), $urandom % 3 == 0,
             $urandom, $urandom & 32'hFFFF_FFFE, 3'($urandom));
      vbr_i = $urandom & 32'hFFFF_F000;
      sp_i  = $urandom;
      step($urandom % 5 != 0, "R1 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule